// File: doc/BRIEF.md
# Acquisition register interface with event FIFO interrupt

This block is the 16-bit slave register front end of a multi-channel charge acquisition module. Converted words arrive on a valid/ready stream and are held in an internal event FIFO. A host reaches the block over a simple synchronous bus with byte addresses. Through that bus it pops event words, reads the FIFO flags, and programs an interrupt level and vector. It also loads a 12-bit test DAC code and fires a one-cycle internal test gate. Several constant identification words can be read.

An access is taken on a rising clock edge while `bus_sel` is high. `bus_wr` chooses between a write and a read. Read data is registered and appears on `bus_rdata` after that edge, where it stays until the next read. Some locations act on any access, read or write alike: one clears the whole module and one fires the test gate.

The event input follows valid/ready rules. A word is stored on an edge where `ev_valid` and `ev_ready` are both high. `ev_ready` is low exactly while the FIFO is full, and a word offered in that state stays with the producer. An interrupt request is raised while the level field is non-zero and the strap-selected FIFO condition holds. It falls as soon as that condition goes false.

Top module: `acq_regbank`

## Requirements
- R1: After reset, the status word (address 0x00) reads 0x0000. `irq_req` and `test_gate` are low, `dac_code` is 0, and `ev_ready` is high.
- R2: In the status word, bit 15 is 1 when the FIFO holds at least one word and bit 14 is 1 when it is full. Bits 13:11 always read 0. Writes to bits 15:11 have no effect.
- R3: Status bits 10:8 hold the interrupt level and bits 7:0 hold the interrupt vector. Both are written and read back at address 0x00, and both are driven on `irq_level` and `irq_vector`.
- R4: A read at 0x08 returns the oldest stored event word and removes it, so words come out in arrival order.
- R5: A read at 0x08 while the FIFO is empty removes nothing. A word pushed afterwards is the next one returned, and the status stays empty until that push.
- R6: `ev_ready` is low while the FIFO is full. A word offered in that state is not stored.
- R7: Any read or write at 0x02 empties the FIFO and returns the level, vector and DAC code to 0. A read there returns 0x0000.
- R8: Any read or write at 0x06 raises `test_gate` for exactly the one cycle after the access edge.
- R9: A write at 0x04 loads `bus_wdata[11:0]` into `dac_code`. A read at 0x04 returns 0x0000 and leaves `dac_code` unchanged.
- R10: Address 0xFA reads 0xFAF5. Address 0xFC reads 0x0812, which is manufacturer code 000010 above model code 0000010010. Address 0xFE reads the 4-bit version above the 12-bit serial number.
- R11: With `irq_src_full` = 0, `irq_req` is high exactly when the level is non-zero and the FIFO is not empty.
- R12: With `irq_src_full` = 1, `irq_req` is high exactly when the level is non-zero and the FIFO is full. It drops in the cycle after a pop leaves the FIFO not full.
- R13: A read at an unmapped address returns 0x0000. A write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_src_full | input | 1 | Static strap: 1 selects FIFO full as the interrupt condition, 0 selects not empty |
| bus_sel | input | 1 | Bus access strobe for this edge |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ev_valid | input | 1 | Event word offered |
| ev_ready | output | 1 | FIFO can accept a word |
| ev_data | input | 16 | Event word |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Programmed interrupt level |
| irq_vector | output | 8 | Programmed interrupt vector |
| dac_code | output | 12 | Test DAC code |
| test_gate | output | 1 | One-cycle internal test gate pulse |

## Verification
The bench builds the block with a FIFO depth of 4, version 1 and serial 0x2A7. With that depth, the full flag, the back-pressure on the stream and the full-sourced interrupt are all reached within four pushes. The non-zero version and serial values show whether the two fields of the version word are placed at the right bit positions. The strap is switched between scenarios so that both interrupt sources are exercised against the same FIFO contents.

// File: rtl/acq_reg_pkg.sv
package acq_reg_pkg;

  localparam int BUS_W  = 16;
  localparam int ADDR_W = 8;
  localparam int DAC_W  = 12;
  localparam int LVL_W  = 3;
  localparam int VEC_W  = 8;

  localparam logic [ADDR_W-1:0] A_STATUS  = 8'h00;
  localparam logic [ADDR_W-1:0] A_CLEAR   = 8'h02;
  localparam logic [ADDR_W-1:0] A_DAC     = 8'h04;
  localparam logic [ADDR_W-1:0] A_TGATE   = 8'h06;
  localparam logic [ADDR_W-1:0] A_DATA    = 8'h08;
  localparam logic [ADDR_W-1:0] A_ID_FIX  = 8'hFA;
  localparam logic [ADDR_W-1:0] A_ID_MAKE = 8'hFC;
  localparam logic [ADDR_W-1:0] A_ID_VER  = 8'hFE;

  localparam logic [BUS_W-1:0] ID_FIXED_WORD = 16'hFAF5;
  localparam logic [5:0]       MAKER_CODE    = 6'b000010;
  localparam logic [9:0]       MODEL_CODE    = 10'b0000010010;

  typedef struct packed {
    logic status;
    logic clear;
    logic dac;
    logic tgate;
    logic data;
    logic id_fix;
    logic id_make;
    logic id_ver;
  } acq_hit_t;

endpackage

// File: rtl/acq_reg_decode.sv
module acq_reg_decode
  import acq_reg_pkg::*;
(
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acq_hit_t          hit_o
);

  always_comb begin
    hit_o = '0;
    if (sel_i) begin
      unique case (addr_i)
        A_STATUS:  hit_o.status  = 1'b1;
        A_CLEAR:   hit_o.clear   = 1'b1;
        A_DAC:     hit_o.dac     = 1'b1;
        A_TGATE:   hit_o.tgate   = 1'b1;
        A_DATA:    hit_o.data    = 1'b1;
        A_ID_FIX:  hit_o.id_fix  = 1'b1;
        A_ID_MAKE: hit_o.id_make = 1'b1;
        A_ID_VER:  hit_o.id_ver  = 1'b1;
        default:   hit_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/acq_evfifo.sv
module acq_evfifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 256
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] data_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic          empty_o,
  output logic          full_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          push_ok, pop_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  assign empty_o = (count == '0);
  assign full_o  = (count == CW'(DEPTH));
  assign push_ok = push_i && !full_o && !clr_i;
  assign pop_ok  = pop_i && !empty_o && !clr_i;
  assign head_o  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R5: a pop on an empty FIFO moves nothing
  assert_empty_pop_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o && !push_i && !clr_i) |=> (empty_o && rd_ptr == $past(rd_ptr)));

  // R6: an offer while full is not written
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full_o && !pop_i && !clr_i) |=> (full_o && wr_ptr == $past(wr_ptr)));

endmodule

// File: rtl/acq_irq_gen.sv
module acq_irq_gen
  import acq_reg_pkg::*;
(
  input  logic             src_full_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic             empty_i,
  input  logic             full_i,
  output logic             irq_o
);

  logic cond;

  always_comb begin
    cond  = src_full_i ? full_i : !empty_i;
    irq_o = (level_i != '0) && cond;
  end

endmodule

// File: rtl/acq_regbank.sv
module acq_regbank
  import acq_reg_pkg::*;
#(
  parameter int          FIFO_DEPTH  = 256,
  parameter logic [3:0]  MOD_VERSION = 4'h0,
  parameter logic [11:0] MOD_SERIAL  = 12'h000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_src_full,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [BUS_W-1:0]  ev_data,
  output logic              irq_req,
  output logic [LVL_W-1:0]  irq_level,
  output logic [VEC_W-1:0]  irq_vector,
  output logic [DAC_W-1:0]  dac_code,
  output logic              test_gate
);

  acq_hit_t         hit;
  logic [BUS_W-1:0] head;
  logic             f_empty, f_full;
  logic             wr_acc, rd_acc;
  logic [BUS_W-1:0] status_word;

  assign wr_acc = bus_sel && bus_wr;
  assign rd_acc = bus_sel && !bus_wr;

  acq_reg_decode u_dec (
    .sel_i  (bus_sel),
    .addr_i (bus_addr),
    .hit_o  (hit)
  );

  acq_evfifo #(.DW(BUS_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (hit.clear),
    .push_i  (ev_valid),
    .data_i  (ev_data),
    .pop_i   (hit.data && !bus_wr),
    .head_o  (head),
    .empty_o (f_empty),
    .full_o  (f_full)
  );

  assign ev_ready = !f_full;

  acq_irq_gen u_irq (
    .src_full_i (irq_src_full),
    .level_i    (irq_level),
    .empty_i    (f_empty),
    .full_i     (f_full),
    .irq_o      (irq_req)
  );

  assign status_word = {!f_empty, f_full, 3'b000, irq_level, irq_vector};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level  <= '0;
      irq_vector <= '0;
      dac_code   <= '0;
      test_gate  <= 1'b0;
    end else begin
      test_gate <= hit.tgate;
      if (hit.clear) begin
        irq_level  <= '0;
        irq_vector <= '0;
        dac_code   <= '0;
      end else if (wr_acc) begin
        if (hit.status) begin
          irq_level  <= bus_wdata[LVL_W+VEC_W-1:VEC_W];
          irq_vector <= bus_wdata[VEC_W-1:0];
        end
        if (hit.dac) dac_code <= bus_wdata[DAC_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (rd_acc) begin
      unique case (1'b1)
        hit.status:  bus_rdata <= status_word;
        hit.data:    bus_rdata <= head;
        hit.id_fix:  bus_rdata <= ID_FIXED_WORD;
        hit.id_make: bus_rdata <= {MAKER_CODE, MODEL_CODE};
        hit.id_ver:  bus_rdata <= {MOD_VERSION, MOD_SERIAL};
        default:     bus_rdata <= '0;
      endcase
    end
  end

  // R7: a clear access empties the FIFO and zeroes the control state
  assert_clear_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit.clear |=> (f_empty && irq_level == '0 && irq_vector == '0 && dac_code == '0));

  // R8: the test gate follows an access by exactly one cycle
  assert_tgate_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit.tgate |=> test_gate);
  assert_tgate_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit.tgate |=> !test_gate);

  // R11: no request while the level field is zero
  assert_irq_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level == '0) |-> !irq_req);

  // R12: full-sourced request is released once the FIFO is not full
  assert_irq_full_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src_full && !f_full) |-> !irq_req);

  // R9: a read at the DAC address keeps the code
  assert_dac_read_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit.dac && !bus_wr) |=> $stable(dac_code));

endmodule

// File: tb/tb_acq_regbank.sv
module tb_acq_regbank;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_src_full = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ev_valid = 1'b0, ev_ready;
  logic [15:0] ev_data = '0;
  logic        irq_req;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vector;
  logic [11:0] dac_code;
  logic        test_gate;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acq_regbank #(.FIFO_DEPTH(DEPTH), .MOD_VERSION(4'h1), .MOD_SERIAL(12'h2A7)) dut (
    .clk(clk), .rst_n(rst_n), .irq_src_full(irq_src_full),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_data(ev_data),
    .irq_req(irq_req), .irq_level(irq_level), .irq_vector(irq_vector),
    .dac_code(dac_code), .test_gate(test_gate)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push(input logic [15:0] d, output logic took);
    ev_valid = 1'b1; ev_data = d; took = ev_ready;
    @(posedge clk); @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic do_clear();
    logic [15:0] r;
    bus_read(8'h02, r);
  endtask

  task automatic t_reset();
    logic [15:0] r;
    chk("R1", "irq_req", 32'(irq_req), 0);
    chk("R1", "test_gate", 32'(test_gate), 0);
    chk("R1", "dac_code", 32'(dac_code), 0);
    chk("R1", "ev_ready", 32'(ev_ready), 1);
    bus_read(8'h00, r);
    chk("R1", "status", 32'(r), 32'h0000);
  endtask

  task automatic t_ctrl_fields();
    logic [15:0] r;
    bus_write(8'h00, 16'hFFFF);
    bus_read(8'h00, r);
    chk("R2", "status top bits ignored", 32'(r), 32'h07FF);
    bus_write(8'h00, 16'h05A3);
    bus_read(8'h00, r);
    chk("R3", "level/vector readback", 32'(r), 32'h05A3);
    chk("R3", "irq_level pin", 32'(irq_level), 5);
    chk("R3", "irq_vector pin", 32'(irq_vector), 32'hA3);
    do_clear();
  endtask

  task automatic t_fifo_order();
    logic [15:0] r; logic tk;
    push(16'h1111, tk); push(16'h2222, tk); push(16'h3333, tk);
    bus_read(8'h00, r);
    chk("R2", "status not empty", 32'(r), 32'h8000);
    bus_read(8'h08, r); chk("R4", "first word", 32'(r), 32'h1111);
    bus_read(8'h08, r); chk("R4", "second word", 32'(r), 32'h2222);
    bus_read(8'h08, r); chk("R4", "third word", 32'(r), 32'h3333);
    bus_read(8'h00, r);
    chk("R4", "status after drain", 32'(r), 32'h0000);
  endtask

  task automatic t_empty_read();
    logic [15:0] r; logic tk;
    bus_read(8'h08, r);
    bus_read(8'h08, r);
    bus_read(8'h00, r);
    chk("R5", "still empty", 32'(r), 32'h0000);
    push(16'h1234, tk);
    bus_read(8'h08, r);
    chk("R5", "pushed word next", 32'(r), 32'h1234);
    bus_read(8'h00, r);
    chk("R5", "empty after pop", 32'(r), 32'h0000);
  endtask

  task automatic t_backpressure();
    logic [15:0] r; logic tk;
    for (int i = 0; i < DEPTH; i++) begin
      push(16'hA000 + 16'(i), tk);
      chk("R6", "accepted before full", 32'(tk), 1);
    end
    chk("R6", "ev_ready low when full", 32'(ev_ready), 0);
    bus_read(8'h00, r);
    chk("R2", "status full", 32'(r), 32'hC000);
    push(16'hBAD0, tk);
    chk("R6", "offer while full refused", 32'(tk), 0);
    for (int i = 0; i < DEPTH; i++) begin
      bus_read(8'h08, r);
      chk("R6", "word intact", 32'(r), 32'(16'hA000 + 16'(i)));
    end
    bus_read(8'h00, r);
    chk("R6", "nothing extra stored", 32'(r), 32'h0000);
  endtask

  task automatic t_clear();
    logic [15:0] r; logic tk;
    push(16'h0101, tk); push(16'h0202, tk);
    bus_write(8'h00, 16'h0377);
    bus_write(8'h04, 16'h0ABC);
    bus_read(8'h02, r);
    chk("R7", "clear read data", 32'(r), 32'h0000);
    chk("R7", "dac after read clear", 32'(dac_code), 0);
    bus_read(8'h00, r);
    chk("R7", "status after read clear", 32'(r), 32'h0000);
    push(16'h0303, tk);
    bus_write(8'h00, 16'h0122);
    bus_write(8'h02, 16'h0000);
    bus_read(8'h00, r);
    chk("R7", "status after write clear", 32'(r), 32'h0000);
  endtask

  task automatic t_test_gate();
    logic [15:0] r;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h06;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    chk("R8", "gate high after read", 32'(test_gate), 1);
    @(negedge clk);
    chk("R8", "gate single cycle", 32'(test_gate), 0);
    bus_write(8'h06, 16'h1234);
    chk("R8", "gate high after write", 32'(test_gate), 1);
    @(negedge clk);
    chk("R8", "gate low again", 32'(test_gate), 0);
    bus_read(8'h00, r);
    chk("R8", "no side effect on status", 32'(r), 32'h0000);
  endtask

  task automatic t_dac();
    logic [15:0] r;
    bus_write(8'h04, 16'hF5A6);
    chk("R9", "dac low 12 bits", 32'(dac_code), 32'h5A6);
    bus_read(8'h04, r);
    chk("R9", "dac read zero", 32'(r), 32'h0000);
    chk("R9", "dac kept after read", 32'(dac_code), 32'h5A6);
  endtask

  task automatic t_ids();
    logic [15:0] r;
    bus_read(8'hFA, r); chk("R10", "fixed word", 32'(r), 32'hFAF5);
    bus_read(8'hFC, r); chk("R10", "maker/model", 32'(r), 32'h0812);
    bus_read(8'hFE, r); chk("R10", "version/serial", 32'(r), 32'h12A7);
  endtask

  task automatic t_unmapped();
    logic [15:0] r;
    bus_write(8'h00, 16'h0244);
    bus_write(8'h40, 16'hFFFF);
    bus_write(8'h05, 16'hFFFF);
    bus_read(8'h40, r);
    chk("R13", "unmapped read", 32'(r), 32'h0000);
    bus_read(8'h00, r);
    chk("R13", "status untouched", 32'(r), 32'h0244);
    chk("R13", "dac untouched", 32'(dac_code), 32'h5A6);
    do_clear();
  endtask

  task automatic t_irq_nonempty();
    logic [15:0] r; logic tk;
    irq_src_full = 1'b0;
    bus_write(8'h00, 16'h035A);
    chk("R11", "no irq while empty", 32'(irq_req), 0);
    push(16'h7777, tk);
    chk("R11", "irq when not empty", 32'(irq_req), 1);
    bus_read(8'h08, r);
    chk("R11", "irq released on empty", 32'(irq_req), 0);
    bus_write(8'h00, 16'h005A);
    push(16'h8888, tk);
    chk("R11", "no irq with level 0", 32'(irq_req), 0);
    do_clear();
  endtask

  task automatic t_irq_full();
    logic [15:0] r; logic tk;
    irq_src_full = 1'b1;
    bus_write(8'h00, 16'h0211);
    for (int i = 0; i < DEPTH - 1; i++) push(16'(i), tk);
    chk("R12", "no irq before full", 32'(irq_req), 0);
    push(16'h00FF, tk);
    chk("R12", "irq on full", 32'(irq_req), 1);
    bus_read(8'h08, r);
    chk("R12", "irq released after pop", 32'(irq_req), 0);
    do_clear();
    irq_src_full = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_fields();
    t_fifo_order();
    t_empty_read();
    t_backpressure();
    t_clear();
    t_test_gate();
    t_dac();
    t_ids();
    t_unmapped();
    t_irq_nonempty();
    t_irq_full();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule